// File: doc/BRIEF.md
# System Call Exception Entry Unit

This unit performs the architectural register update that happens when a processor takes a system-call trap. A one-cycle request strobe tells the unit to act on the machine state it sees on its inputs. On that edge the unit does four things at once:

- it copies the current program counter into save register 0;
- it copies the unmodified machine-state word into save register 1;
- it redirects the program counter to the trap vector;
- it writes back a machine-state word with six control bits forced to zero.

The trap vector takes its upper half from the upper half of a vector prefix register. Its lower half is a fixed offset of 0x0C00.

The surrounding core uses the four outputs as its new architectural state. A one-cycle done pulse follows each accepted request. A request that arrives while done is high is dropped. Bit numbering throughout is little-endian: bit 0 is the least significant bit of a 32-bit word.

Top module: `sc_entry_unit`

## Requirements
- R1: One cycle after an accepted request, `save1_o` equals the value of `msr_i` at the request edge, with no bits cleared.
- R2: One cycle after an accepted request, `save0_o` equals the value of `pc_i` at the request edge.
- R3: One cycle after an accepted request, `pc_o[31:16]` equals `vpfx_i[31:16]` at the request edge and `pc_o[15:0]` equals 16'h0C00. `vpfx_i[15:0]` has no effect on any output.
- R4: One cycle after an accepted request, `msr_o` has bits 18 (wait enable), 17 (critical interrupt enable), 15 (external interrupt enable), 14 (user mode), 5 (instruction translation) and 4 (data translation) equal to zero. The cleared set is therefore mask 32'h0006_C030.
- R5: Every other bit of `msr_o` equals the matching bit of `msr_i` at the request edge.
- R6: `done_o` is high for exactly the one cycle after an accepted request, and low otherwise. All four outputs take their new values on the same edge that raises `done_o`.
- R7: A request that is sampled while `done_o` is high is ignored. Afterwards `done_o` goes low and all four outputs keep their previous values.
- R8: Without an accepted request, all outputs hold their values. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | System-call request strobe |
| pc_i | input | 32 | Current program counter |
| msr_i | input | 32 | Current machine-state word |
| vpfx_i | input | 32 | Vector prefix register; only the upper half is used |
| pc_o | output | 32 | Updated program counter (trap vector) |
| save0_o | output | 32 | Save register 0: the saved program counter |
| save1_o | output | 32 | Save register 1: the saved machine-state word |
| msr_o | output | 32 | Updated machine-state word |
| done_o | output | 1 | One-cycle pulse after an accepted request |

## Verification
The bench drives back-to-back requests, because a design that checks only `req_i` would accept the second one: `done_o` would stay high and the saved values would change. The prefix register carries non-zero low bits, which catches a vector that takes the wrong half of the prefix or ORs the offset into it. Machine-state words of all ones, all zeros and mixed patterns show whether a mask clears the wrong bit or clears save register 1 as well. Those words also show whether a mask leaves one of the six bits set. Idle gaps between requests expose outputs that drift without a request and a done pulse that lasts longer than one cycle.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned NCLR = 6;

  typedef logic [XLEN-1:0] word_t;

  typedef struct packed {
    word_t pc;
    word_t save0;
    word_t save1;
    word_t msr;
  } arch_state_t;

  function automatic logic pos_hit(input int unsigned bitn,
                                   input int unsigned p0, input int unsigned p1,
                                   input int unsigned p2, input int unsigned p3,
                                   input int unsigned p4, input int unsigned p5);
    return (bitn == p0) || (bitn == p1) || (bitn == p2) ||
           (bitn == p3) || (bitn == p4) || (bitn == p5);
  endfunction
endpackage

// File: rtl/sce_vector.sv
module sce_vector
  import sce_pkg::*;
#(
  parameter logic [HALF-1:0] VEC_OFFSET = 16'h0C00
) (
  input  logic [HALF-1:0] pfx_hi_i,
  output word_t           vec_o
);
  always_comb begin
    vec_o = {pfx_hi_i, VEC_OFFSET};
  end

  always_comb begin
    // R3: low half of the vector is the fixed offset
    a_r3_offset: assert (vec_o[HALF-1:0] == VEC_OFFSET);
  end
endmodule

// File: rtl/sce_msr_mask.sv
module sce_msr_mask
  import sce_pkg::*;
#(
  parameter int unsigned POS_WAIT = 18,
  parameter int unsigned POS_CRIT = 17,
  parameter int unsigned POS_EXT  = 15,
  parameter int unsigned POS_USER = 14,
  parameter int unsigned POS_ITR  = 5,
  parameter int unsigned POS_DTR  = 4
) (
  input  word_t msr_i,
  output word_t msr_o
);
  word_t clr_mask;

  for (genvar i = 0; i < XLEN; i++) begin : g_mask
    assign clr_mask[i] = pos_hit(i, POS_WAIT, POS_CRIT, POS_EXT,
                                 POS_USER, POS_ITR, POS_DTR);
  end

  always_comb begin
    msr_o = msr_i & ~clr_mask;
  end

  always_comb begin
    // R4: the six control bits leave as zero
    a_r4_cleared: assert ((msr_o & clr_mask) == '0);
    // R5: all other bits pass through
    a_r5_preserved: assert ((msr_o | clr_mask) == (msr_i | clr_mask));
    // R4: exactly NCLR distinct positions are configured
    a_r4_count: assert ($countones(clr_mask) == NCLR);
  end
endmodule

// File: rtl/sce_state_regs.sv
module sce_state_regs
  import sce_pkg::*;
#(
  parameter logic [HALF-1:0] VEC_OFFSET = 16'h0C00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  arch_state_t nxt_i,
  input  word_t       pc_cur_i,
  input  word_t       msr_cur_i,
  input  logic [HALF-1:0] pfx_hi_i,
  output arch_state_t st_o,
  output logic        done_o
);
  arch_state_t st_q, st_d;
  logic        done_q, done_d;
  logic        accept;
  logic        st_en;

  always_comb begin
    accept = req_i & ~done_q;
    st_en  = accept;
    st_d   = st_q;
    if (st_en) begin
      st_d = nxt_i;
    end
    done_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (st_en) begin
        st_q <= st_d;
      end
      done_q <= done_d;
    end
  end

  assign st_o   = st_q;
  assign done_o = done_q;

  a_r1_save_msr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !done_o) |=> (st_o.save1 == $past(msr_cur_i)));
  a_r2_save_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !done_o) |=> (st_o.save0 == $past(pc_cur_i)));
  a_r3_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !done_o) |=> (st_o.pc == {$past(pfx_hi_i), VEC_OFFSET}));
  a_r6_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !done_o) |=> done_o);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && done_o) |=> ($stable(st_o) && !done_o));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(st_o));
endmodule

// File: rtl/sc_entry_unit.sv
module sc_entry_unit
  import sce_pkg::*;
#(
  parameter logic [15:0] VEC_OFFSET = 16'h0C00,
  parameter int unsigned POS_WAIT   = 18,
  parameter int unsigned POS_CRIT   = 17,
  parameter int unsigned POS_EXT    = 15,
  parameter int unsigned POS_USER   = 14,
  parameter int unsigned POS_ITR    = 5,
  parameter int unsigned POS_DTR    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] msr_i,
  input  logic [31:0] vpfx_i,
  output logic [31:0] pc_o,
  output logic [31:0] save0_o,
  output logic [31:0] save1_o,
  output logic [31:0] msr_o,
  output logic        done_o
);
  word_t       vec;
  word_t       msr_clr;
  arch_state_t nxt;
  arch_state_t st;
  logic        unused_pfx_lo;

  assign unused_pfx_lo = ^vpfx_i[HALF-1:0];

  sce_vector #(.VEC_OFFSET(VEC_OFFSET)) u_vec (
    .pfx_hi_i (vpfx_i[XLEN-1:HALF]),
    .vec_o    (vec)
  );

  sce_msr_mask #(
    .POS_WAIT (POS_WAIT),
    .POS_CRIT (POS_CRIT),
    .POS_EXT  (POS_EXT),
    .POS_USER (POS_USER),
    .POS_ITR  (POS_ITR),
    .POS_DTR  (POS_DTR)
  ) u_mask (
    .msr_i (msr_i),
    .msr_o (msr_clr)
  );

  always_comb begin
    nxt.pc    = vec;
    nxt.save0 = pc_i;
    nxt.save1 = msr_i;
    nxt.msr   = msr_clr;
  end

  sce_state_regs #(.VEC_OFFSET(VEC_OFFSET)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .nxt_i     (nxt),
    .pc_cur_i  (pc_i),
    .msr_cur_i (msr_i),
    .pfx_hi_i  (vpfx_i[XLEN-1:HALF]),
    .st_o      (st),
    .done_o    (done_o)
  );

  assign pc_o    = st.pc;
  assign save0_o = st.save0;
  assign save1_o = st.save1;
  assign msr_o   = st.msr;
endmodule

// File: tb/sim_sc_entry_unit.sv
module sim_sc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] pc_i = '0, msr_i = '0, vpfx_i = '0;
  logic [31:0] pc_o, save0_o, save1_o, msr_o;
  logic        done_o;

  localparam logic [31:0] CLR = 32'h0006_C030;

  typedef struct { logic [31:0] pc, s0, s1, msr; } exp_t;
  exp_t q[$];
  exp_t last;
  int   checks = 0, errors = 0;
  bit   busy = 0, armed = 0, ended = 0;

  always #2 clk = ~clk;

  sc_entry_unit u0 (.*);

  function automatic exp_t model(logic [31:0] pc, logic [31:0] msr, logic [31:0] pf);
    exp_t e;
    e.pc = {pf[31:16], 16'h0C00};
    e.s0 = pc;
    e.s1 = msr;
    e.msr = msr & ~CLR;
    return e;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] pc, logic [31:0] msr, logic [31:0] pf);
    bit acc;
    pc_i = pc; msr_i = msr; vpfx_i = pf; req_i = 1'b1;
    @(posedge clk);
    acc = !busy;
    busy = acc;
    if (acc) begin
      last = model(pc, msr, pf);
      q.push_back(last);
    end
    @(negedge clk);
    req_i = 1'b0;
    if (!acc) begin
      // R7: ignored request leaves outputs untouched
      chk("R7 pc", pc_o, last.pc);
      chk("R7 save0", save0_o, last.s0);
      chk("R7 save1", save1_o, last.s1);
      chk("R7 msr", msr_o, last.msr);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      req_i = 1'b0;
      pc_i = pc_i ^ 32'h1357_9BDF;
      msr_i = ~msr_i;
      vpfx_i = vpfx_i + 32'h0001_0001;
      @(posedge clk);
      busy = 0;
      @(negedge clk);
      // R8: idle cycles hold the outputs
      chk("R8 hold pc", pc_o, last.pc);
      chk("R8 hold msr", msr_o, last.msr);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (done_o !== (q.size() != 0)) begin
        errors++;
        $display("FAIL R6 done actual=%b expected=%b", done_o, q.size() != 0);
      end
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R3 vector", pc_o, e.pc);
        chk("R2 save0", save0_o, e.s0);
        chk("R1 save1", save1_o, e.s1);
        chk("R4/R5 msr", msr_o, e.msr);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    last = '{default: '0};
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset pc", pc_o, 32'h0);
    chk("R8 reset save0", save0_o, 32'h0);
    chk("R8 reset save1", save1_o, 32'h0);
    chk("R8 reset msr", msr_o, 32'h0);
    chk("R8 reset done", {31'h0, done_o}, 32'h0);
    rst_n = 1'b1;
    armed = 1;
    idle(2);
    issue(32'h0000_1004, 32'hFFFF_FFFF, 32'hABCD_FFFF); // R4 all ones
    idle(3);
    issue(32'hDEAD_BEE0, 32'h0000_0000, 32'h1234_5678); // R3 low bits ignored
    idle(1);
    issue(32'h8000_0010, 32'h0006_C030, 32'hFFFF_0000); // R4 only cleared bits set
    issue(32'h1111_2222, 32'h5A5A_A5A5, 32'h0000_FFFF); // R7 back-to-back
    idle(2);
    issue(32'hFFFF_FFFC, 32'hFFF9_3FCF, 32'h7F00_1234); // R5 everything else set
    issue(32'h2222_3333, 32'h1234_5678, 32'h1111_1111); // R7
    issue(32'h4444_5550, 32'hA5A5_5A5A, 32'hC3C3_3C3C); // R6 accepted again
    idle(2);
    for (int k = 0; k < 8; k++) begin
      issue(32'h0100_0000 * k + 32'h40, 32'h9E37_79B9 * (k + 1), 32'h0BAD_0000 ^ (k << 20));
      idle(k % 3);
    end
    idle(2);
    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule